// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This core completes one instruction in every clock cycle. The program counter addresses an external instruction store, which returns a word in the same cycle. The core decodes the word in one of three layouts: register, immediate or jump. It reads two source registers and computes a result in the ALU, or a load/store address. It may read or write an external word-wide data store. The result is written back and the next program counter is selected, all before the next rising edge. There is no pipeline, so no hazard exists between back-to-back instructions.

The field layout is fixed. The opcode is in bits 31:26 and the first source register index is in bits 25:21. The second source register index, which is the destination for immediate forms, is in bits 20:16. The register-form destination is in bits 15:11, with funct in bits 5:0. Immediate forms hold a 16-bit signed constant in bits 15:0, and jump forms hold a 26-bit word target in bits 25:0. The register commit is visible on a write-back port, so an environment can follow architectural state one instruction at a time.

Top module: `sc_core`

## Requirements
- R1: After the active-low reset is released, the PC is 0. Register 29 holds 128 and every other register holds 0. While reset is low, `imem_addr` is 0.
- R2: Register 0 always reads as 0. An instruction that targets register 0 raises no write-back (`wb_en` stays 0) and leaves register 0 at 0.
- R3: With opcode 0, these funct codes write the result to register rd: 100001 gives rs+rt, 100011 gives rs−rt, 100100 gives rs AND rt, and 100101 gives rs OR rt. Funct 101010 gives 1 when rs is less than rt as signed values, and 0 otherwise. Funct 011000 gives the low 32 bits of rs×rt.
- R4: Opcode 001000 writes rs plus the sign-extended 16-bit immediate into rt.
- R5: Opcode 100011 raises `dmem_re`, lowers `dmem_we` and writes `dmem_rdata` into rt. The word address on `dmem_waddr` is bits [DMEM_AW+1:2] of rs plus the sign-extended immediate, so the two lowest byte-address bits are dropped.
- R6: Opcode 101011 raises `dmem_we` and lowers `dmem_re`. It drives rt on `dmem_wdata` at the word address defined in R5 and makes no write-back.
- R7: The all-zero word makes no write-back and no data access, and the PC advances by 4.
- R8: Each conditional branch, when taken, loads PC+4 plus the sign-extended immediate shifted left by 2. When not taken, the PC advances by 4. Opcode 000100 branches when rs equals rt. Opcode 000110 branches when rs ≤ rt (signed). Opcode 000101 with rt = 0 branches when rs is not 0. Opcode 000001 branches when rs < 0 (signed).
- R9: Opcode 000010 loads the PC with {PC[31:28], target[25:0], 2'b00}.
- R10: Opcode 000011 loads the same target as R9. In the same cycle it writes PC+4 into register 31.
- R11: Opcode 0 with funct 001000 loads the PC with the value of rs and makes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_word | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_waddr | output | DMEM_AW | Word address for the data store |
| dmem_re | output | 1 | Load in progress |
| dmem_we | output | 1 | Store: write `dmem_wdata` at the next rising edge |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Word read at `dmem_waddr`, same cycle |
| wb_en | output | 1 | A register is written at the next rising edge |
| wb_idx | output | 5 | Index of the register being written |
| wb_val | output | 32 | Value being written |

## Verification
The bench uses the defaults: DMEM_AW = 7 (128 data words), a stack-pointer preset of 128 and a reset PC of 0. With the preset base of 128, offsets of +8, +11 and −128 reach data words 34 and 0. The +11 offset shows that the low address bits are dropped, and the −128 offset shows sign extension into the address. The program jumps to 0x100, 0x200 and 0x300 in the 256-word instruction store it serves. It also branches backward, so jump targets, the link return and negative branch offsets are all exercised.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BLE   = 6'b000110;
  localparam logic [5:0] OP_BNZ   = 6'b000101;
  localparam logic [5:0] OP_BLTZ  = 6'b000001;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] OP_CALL  = 6'b000011;

  localparam logic [5:0] FN_ADD = 6'b100001;
  localparam logic [5:0] FN_SUB = 6'b100011;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_MUL = 6'b011000;
  localparam logic [5:0] FN_JR  = 6'b001000;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_MUL} alu_e;
  typedef enum logic [2:0] {BR_NONE, BR_EQ, BR_LE, BR_NZ, BR_LTZ} br_e;
  typedef enum logic [1:0] {NX_SEQ, NX_BRANCH, NX_JUMP, NX_REG} nxt_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_e;

  typedef struct packed {
    logic reg_we;
    dst_e dst;
    logic use_imm;
    logic mem_rd;
    logic mem_wr;
    alu_e alu;
    br_e  br;
    nxt_e nxt;
    logic link;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [2*XLEN-1:0] prod;
    prod = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    case (op)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      ALU_MUL: return prod[XLEN-1:0];
      default: return a + b;
    endcase
  endfunction

  function automatic logic br_check(input br_e kind,
                                    input logic [XLEN-1:0] a,
                                    input logic [XLEN-1:0] b);
    case (kind)
      BR_EQ:   return a == b;
      BR_LE:   return $signed(a) <= $signed(b);
      BR_NZ:   return a != b;
      BR_LTZ:  return a[XLEN-1];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_we: 1'b0, dst: DST_RD, use_imm: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
             alu: ALU_ADD, br: BR_NONE, nxt: NX_SEQ, link: 1'b0};
    case (op)
      OP_RTYPE: begin
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD: ctrl.alu = ALU_ADD;
          FN_SUB: ctrl.alu = ALU_SUB;
          FN_AND: ctrl.alu = ALU_AND;
          FN_OR:  ctrl.alu = ALU_OR;
          FN_SLT: ctrl.alu = ALU_SLT;
          FN_MUL: ctrl.alu = ALU_MUL;
          FN_JR: begin
            ctrl.reg_we = 1'b0;
            ctrl.nxt    = NX_REG;
          end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1;
      end
      OP_LOAD: begin
        ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1;
      end
      OP_BEQ:  begin ctrl.br = BR_EQ;  ctrl.nxt = NX_BRANCH; end
      OP_BLE:  begin ctrl.br = BR_LE;  ctrl.nxt = NX_BRANCH; end
      OP_BNZ:  begin ctrl.br = BR_NZ;  ctrl.nxt = NX_BRANCH; end
      OP_BLTZ: begin ctrl.br = BR_LTZ; ctrl.nxt = NX_BRANCH; end
      OP_JMP:  ctrl.nxt = NX_JUMP;
      OP_CALL: begin
        ctrl.nxt = NX_JUMP; ctrl.link = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = DST_LINK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int              NREG    = 32,
  parameter int              W       = XLEN,
  parameter int              SP_IDX  = 29,
  parameter logic [W-1:0]    SP_INIT = 128,
  localparam int             IW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_val,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_val,
  input  logic          we,
  input  logic [IW-1:0] w_idx,
  input  logic [W-1:0]  w_val
);
  logic [W-1:0] regs [NREG];
  logic         fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
      fresh <= 1'b1;
    end else begin
      fresh <= 1'b0;
      if (we && w_idx != '0) regs[w_idx] <= w_val;
    end
  end

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];

  // R1: preset values visible on the first cycle out of reset
  p_sp_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (regs[SP_IDX] == SP_INIT && regs[1] == '0));
  // R2: the zero register never changes
  p_zero_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);
endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [25:0]     target,
  input  logic [XLEN-1:0] imm_sx,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  br_e             br,
  input  nxt_e            nxt,
  output logic [XLEN-1:0] pc_plus4,
  output logic [XLEN-1:0] pc_next,
  output logic            redirect
);
  logic taken;

  assign pc_plus4 = pc + XLEN'(4);
  assign taken    = br_check(br, rs_val, rt_val);

  always_comb begin
    case (nxt)
      NX_BRANCH: pc_next = taken ? pc_plus4 + {imm_sx[XLEN-3:0], 2'b00} : pc_plus4;
      NX_JUMP:   pc_next = {pc[XLEN-1:XLEN-4], target, 2'b00};
      NX_REG:    pc_next = rs_val;
      default:   pc_next = pc_plus4;
    endcase
  end

  assign redirect = (nxt == NX_JUMP) || (nxt == NX_REG) || (nxt == NX_BRANCH && taken);

  // R9: a jump keeps the upper four PC bits
  always_comb begin
    if (nxt == NX_JUMP) a_jump_region_r9: assert (pc_next[XLEN-1:XLEN-4] == pc[XLEN-1:XLEN-4]);
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int             DMEM_AW  = 7,
  parameter logic [31:0]    RESET_PC = 32'h0,
  parameter logic [31:0]    SP_INIT  = 32'd128,
  localparam int            LINK_IDX = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [31:0]        imem_addr,
  input  logic [31:0]        imem_word,
  output logic [DMEM_AW-1:0] dmem_waddr,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [31:0]        dmem_wdata,
  input  logic [31:0]        dmem_rdata,
  output logic               wb_en,
  output logic [4:0]         wb_idx,
  output logic [31:0]        wb_val
);
  logic [XLEN-1:0] pc, pc_next, pc_plus4, imm_sx, rs_val, rt_val, alu_b, alu_y;
  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic            redirect;
  ctrl_t           ctrl;

  assign rs_idx = imem_word[25:21];
  assign rt_idx = imem_word[20:16];
  assign rd_idx = imem_word[15:11];
  assign imm_sx = sext16(imem_word[15:0]);

  sc_decode u_dec (.op(imem_word[31:26]), .funct(imem_word[5:0]), .ctrl(ctrl));

  sc_regfile #(.NREG(32), .W(XLEN), .SP_IDX(29), .SP_INIT(SP_INIT)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(rs_idx), .ra_val(rs_val),
    .rb_idx(rt_idx), .rb_val(rt_val),
    .we(wb_en), .w_idx(dst_idx), .w_val(wb_val));

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;
  assign alu_y = alu_eval(ctrl.alu, rs_val, alu_b);

  sc_nextpc u_npc (
    .pc(pc), .target(imem_word[25:0]), .imm_sx(imm_sx),
    .rs_val(rs_val), .rt_val(rt_val), .br(ctrl.br), .nxt(ctrl.nxt),
    .pc_plus4(pc_plus4), .pc_next(pc_next), .redirect(redirect));

  always_comb begin
    case (ctrl.dst)
      DST_RT:   dst_idx = rt_idx;
      DST_LINK: dst_idx = RIDX'(LINK_IDX);
      default:  dst_idx = rd_idx;
    endcase
  end

  assign wb_en  = ctrl.reg_we && (dst_idx != '0);
  assign wb_idx = dst_idx;
  assign wb_val = ctrl.link ? pc_plus4 : (ctrl.mem_rd ? dmem_rdata : alu_y);

  assign dmem_waddr = alu_y[DMEM_AW+1:2];
  assign dmem_re    = ctrl.mem_rd;
  assign dmem_we    = ctrl.mem_wr;
  assign dmem_wdata = rt_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_next;
  end
  assign imem_addr = pc;

  // R2: a committed write never targets register 0
  p_no_zero_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_idx != '0);
  // R5: a load never also stores
  p_load_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |-> !dmem_we);
  // R6: a store makes no write-back
  p_store_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (!wb_en && !dmem_re));
  // R7: the all-zero word touches nothing and falls through
  p_nop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    imem_word == '0 |-> (!wb_en && !dmem_we && !dmem_re && !redirect));
  // R7: without a redirect the PC steps by one word
  p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> imem_addr == $past(imem_addr) + 32'd4);
  // R10: the call writes its return address into the link register
  p_link_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.link |-> (wb_en && wb_idx == 5'd31 && wb_val == imem_addr + 32'd4));
  // R11: a register jump lands on the source value
  p_reg_jump_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.nxt == NX_REG) |=> imem_addr == $past(rs_val));
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_word, dmem_wdata, dmem_rdata, wb_val;
  logic [6:0]  dmem_waddr;
  logic        dmem_re, dmem_we, wb_en;
  logic [4:0]  wb_idx;

  always #2 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_word(imem_word),
    .dmem_waddr(dmem_waddr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val));

  logic [31:0] rom [256];
  logic [31:0] ram [128];
  assign imem_word  = rom[imem_addr[9:2]];
  assign dmem_rdata = ram[dmem_waddr];
  always @(posedge clk) if (dmem_we) ram[dmem_waddr] <= dmem_wdata;

  typedef struct {
    logic [31:0] pc;
    logic        wbe;
    logic [4:0]  idx;
    logic [31:0] val;
    logic        we;
    logic        re;
    logic [6:0]  addr;
    logic [31:0] wdata;
    string       tag;
  } exp_t;
  exp_t expq[$];

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
    return {6'b0, rs, rt, rd, 5'b0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input int imm);
    logic [31:0] t;
    t = imm;
    return {op, rs, rt, t[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [31:0] dest);
    return {op, dest[27:2]};
  endfunction

  // driver: place word, queue the expected commit of that cycle
  task automatic step(input logic [31:0] pc, input logic [31:0] w,
                      input logic wbe, input logic [4:0] idx, input logic [31:0] val,
                      input logic we, input logic re, input logic [6:0] addr,
                      input logic [31:0] wdata, input string tag);
    exp_t e;
    rom[pc[9:2]] = w;
    e.pc = pc; e.wbe = wbe; e.idx = idx; e.val = val; e.we = we; e.re = re;
    e.addr = addr; e.wdata = wdata; e.tag = tag;
    expq.push_back(e);
  endtask
  task automatic s_wb(input logic [31:0] pc, input logic [31:0] w, input logic [4:0] idx,
                      input logic [31:0] val, input string tag);
    step(pc, w, 1'b1, idx, val, 1'b0, 1'b0, '0, '0, tag);
  endtask
  task automatic s_none(input logic [31:0] pc, input logic [31:0] w, input string tag);
    step(pc, w, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  localparam logic [5:0] ADDU = 6'b100001, SUBU = 6'b100011, ANDF = 6'b100100,
                         ORF = 6'b100101, SLTF = 6'b101010, MULF = 6'b011000, JRF = 6'b001000;
  localparam logic [5:0] ADDI = 6'b001000, LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100,
                         BLE = 6'b000110, BNZ = 6'b000101, BLTZ = 6'b000001,
                         JMP = 6'b000010, JAL = 6'b000011;

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = '0;
    for (int i = 0; i < 128; i++) ram[i] = '0;
    ram[0] = 32'h0001_0001;
    s_wb  (32'h00, enc_r(ADDU, 29, 0, 8), 8, 32'd128, "R1");
    s_wb  (32'h04, enc_r(ADDU, 5, 0, 9), 9, 32'd0, "R1");
    s_wb  (32'h08, enc_i(ADDI, 0, 10, 100), 10, 32'd100, "R4");
    s_wb  (32'h0C, enc_i(ADDI, 0, 11, -7), 11, 32'hFFFF_FFF9, "R4");
    s_wb  (32'h10, enc_r(ADDU, 10, 11, 12), 12, 32'd93, "R3");
    s_wb  (32'h14, enc_r(SUBU, 11, 10, 13), 13, 32'hFFFF_FF95, "R3");
    s_wb  (32'h18, enc_r(ANDF, 10, 11, 14), 14, 32'h0000_0060, "R3");
    s_wb  (32'h1C, enc_r(ORF, 10, 11, 15), 15, 32'hFFFF_FFFD, "R3");
    s_wb  (32'h20, enc_r(SLTF, 11, 10, 16), 16, 32'd1, "R3");
    s_wb  (32'h24, enc_r(SLTF, 10, 11, 17), 17, 32'd0, "R3");
    s_wb  (32'h28, enc_r(MULF, 10, 11, 18), 18, 32'hFFFF_FD44, "R3");
    s_none(32'h2C, enc_i(ADDI, 0, 0, 55), "R2");
    s_wb  (32'h30, enc_r(ADDU, 0, 0, 20), 20, 32'd0, "R2");
    step  (32'h34, enc_i(SW, 8, 10, 8), 1'b0, 0, 0, 1'b1, 1'b0, 7'd34, 32'd100, "R6");
    step  (32'h38, enc_i(LW, 8, 21, 11), 1'b1, 21, 32'd100, 1'b0, 1'b1, 7'd34, 0, "R5");
    step  (32'h3C, enc_i(LW, 8, 22, -128), 1'b1, 22, 32'h0001_0001, 1'b0, 1'b1, 7'd0, 0, "R5");
    s_wb  (32'h40, enc_r(MULF, 22, 22, 23), 23, 32'h0002_0001, "R3");
    s_none(32'h44, 32'h0, "R7");
    s_none(32'h48, enc_i(BEQ, 10, 10, 3), "R8");
    s_none(32'h58, enc_i(BEQ, 10, 11, 5), "R8");
    s_none(32'h5C, enc_i(BLE, 11, 10, 2), "R8");
    s_none(32'h68, enc_i(BLE, 10, 11, 9), "R8");
    s_none(32'h6C, enc_i(BLE, 10, 10, 1), "R8");
    s_none(32'h74, enc_i(BNZ, 0, 0, 4), "R8");
    s_none(32'h78, enc_i(BNZ, 11, 0, 1), "R8");
    s_none(32'h80, enc_i(BLTZ, 11, 0, 1), "R8");
    s_none(32'h88, enc_i(BLTZ, 10, 0, 7), "R8");
    s_none(32'h8C, enc_i(BLTZ, 0, 0, 7), "R8");
    s_none(32'h90, enc_j(JMP, 32'h100), "R9");
    s_wb  (32'h100, enc_j(JAL, 32'h200), 31, 32'h104, "R10");
    s_wb  (32'h200, enc_i(ADDI, 0, 24, 32'h300), 24, 32'h300, "R4");
    s_none(32'h204, enc_r(JRF, 24, 0, 0), "R11");
    s_none(32'h300, enc_r(JRF, 31, 0, 0), "R11");
    s_wb  (32'h104, enc_r(ADDU, 31, 0, 25), 25, 32'h104, "R10");
    step  (32'h108, enc_i(SW, 0, 13, 0), 1'b0, 0, 0, 1'b1, 1'b0, 7'd0, 32'hFFFF_FF95, "R6");
    step  (32'h10C, enc_i(LW, 0, 26, 0), 1'b1, 26, 32'hFFFF_FF95, 1'b0, 1'b1, 7'd0, 0, "R5");
    s_none(32'h110, enc_i(BEQ, 0, 0, 8), "R8");
    s_none(32'h134, enc_i(BEQ, 0, 0, -9), "R8");
    s_wb  (32'h114, enc_i(ADDI, 0, 27, 1), 27, 32'd1, "R8");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 32'h0, "R1", "pc in reset", imem_addr, 32'h0);
    @(posedge clk);
    #1 rst_n = 1'b1;
  end

  // monitor: pop one expected commit per cycle
  initial begin
    exp_t e;
    @(posedge rst_n);
    while (expq.size() > 0) begin
      @(negedge clk);
      e = expq.pop_front();
      chk(imem_addr == e.pc, e.tag, "pc", imem_addr, e.pc);
      chk(wb_en == e.wbe, e.tag, "wb_en", {31'b0, wb_en}, {31'b0, e.wbe});
      if (e.wbe) begin
        chk(wb_idx == e.idx, e.tag, "wb_idx", {27'b0, wb_idx}, {27'b0, e.idx});
        chk(wb_val == e.val, e.tag, "wb_val", wb_val, e.val);
      end
      chk(dmem_we == e.we, e.tag, "dmem_we", {31'b0, dmem_we}, {31'b0, e.we});
      chk(dmem_re == e.re, e.tag, "dmem_re", {31'b0, dmem_re}, {31'b0, e.re});
      if (e.we || e.re)
        chk(dmem_waddr == e.addr, e.tag, "dmem_waddr", {25'b0, dmem_waddr}, {25'b0, e.addr});
      if (e.we)
        chk(dmem_wdata == e.wdata, e.tag, "dmem_wdata", dmem_wdata, e.wdata);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "WATCHDOG", "timeout", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule